// File: doc/BRIEF.md
# Multichannel DAC command and clear controller

This block sits between a command source and a bank of digital-to-analog converter channels. Each command is one parallel word with a 2-bit bank select, a 5-bit address and a data field, qualified by a valid strobe. A non-zero bank select writes the gain, offset or data register of the addressed channel. A zero bank select picks a special function by address: no-op, load the clear code, soft clear, soft power-down, soft power-up or soft reset.

The block holds a user-loadable clear code. A soft clear, or a low level on the hardware clear input, copies that code into every channel's data register. Soft clear, power-up and soft reset each hold the active-low busy output low for their own duration. Each duration is a number of microseconds multiplied by one clock-frequency parameter. A command that arrives while busy is low is dropped and sets a sticky flag. The effective power-down output is the OR of a software flag and a hardware input. While it is high, every register write is blocked.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: After reset, busy_n_o is 1, pd_o is 0, cmd_drop_o is 0, the clear code is 0, every data and offset register is 0, and every gain register is all ones.
- R2: An accepted command with bank select 2'b11 writes the data register, 2'b10 the offset register and 2'b01 the gain register of channel cmd_addr_i. The new value shows on the outputs after that clock edge. Addresses at or above NCH change nothing.
- R3: Bank select 2'b00 with address 5'h01 stores cmd_data_i into the clear code.
- R4: Bank select 2'b00 with address 5'h02 copies the clear code into every data register, whatever the data field holds. busy_n_o is then low for exactly CLK_MHZ*CLR_US cycles, starting in the cycle after acceptance.
- R5: A low hw_clr_n_i sampled at a clock edge loads the clear code into every data register. It takes precedence over a data write at the same edge.
- R6: Bank select 2'b00 with address 5'h08 sets the software power-down flag. pd_o equals that flag ORed with hw_pd_i.
- R7: While pd_o is high, channel writes, clear-code writes, soft clear and hardware clear change no register. A soft clear in this state also starts no busy window.
- R8: Bank select 2'b00 with address 5'h09 clears the software power-down flag, even while powered down. busy_n_o is then low for CLK_MHZ*PUP_US cycles.
- R9: Bank select 2'b00 with address 5'h0F is accepted even while powered down. It sets every gain to all ones and every offset, data register and the clear code to 0, and it clears the software power-down flag and cmd_drop_o. busy_n_o is then low for CLK_MHZ*RST_US cycles.
- R10: A valid command seen while busy_n_o is low has no effect and sets cmd_drop_o. The flag stays set until reset or an accepted soft reset.
- R11: Bank select 2'b00 with address 5'h00, or with any address not listed above, changes no register and starts no busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_sel_i | input | 2 | Bank select (00 selects special functions) |
| cmd_addr_i | input | 5 | Channel index or function code |
| cmd_data_i | input | DW | Data field |
| hw_clr_n_i | input | 1 | Hardware clear, active low, level sensitive |
| hw_pd_i | input | 1 | Hardware power-down request |
| busy_n_o | output | 1 | Low while a timed command executes |
| pd_o | output | 1 | Effective power-down state |
| cmd_drop_o | output | 1 | Sticky flag: a command was dropped while busy |
| clr_code_o | output | DW | Current clear code |
| dac_data_o | output | NCH*DW | Data registers, channel i at bits i*DW upward |
| gain_o | output | NCH*DW | Gain registers, same packing |
| offset_o | output | NCH*DW | Offset registers, same packing |

## Verification
The bench builds the block with NCH = 8 and CLK_MHZ = 2. This gives busy windows of 70, 16 and 270 cycles, so each window can be followed from its first low cycle to its release, and a command can be placed inside one. With only eight channels, bank writes to addresses 8 to 31 fall outside the bank, which tests the out-of-range rule. Every check compares all channel registers, the clear code and the flags against a reference model, so a stray write to any channel is caught.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

  localparam int ADDR_W = 5;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    BANK_SFR  = 2'b00,
    BANK_GAIN = 2'b01,
    BANK_OFFS = 2'b10,
    BANK_DATA = 2'b11
  } bank_e;

  typedef enum logic [ADDR_W-1:0] {
    SF_NOP     = 5'h00,
    SF_CODEWR  = 5'h01,
    SF_SOFTCLR = 5'h02,
    SF_PDOWN   = 5'h08,
    SF_PUP     = 5'h09,
    SF_SRESET  = 5'h0F
  } sf_e;

  typedef struct packed {
    logic  chan_wr;
    bank_e bank;
    logic  code_wr;
    logic  soft_clr;
    logic  pdown;
    logic  pup;
    logic  sreset;
  } act_t;

endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
(
  input  logic              valid,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy_n,
  input  logic              pd,
  output act_t              act,
  output logic              drop
);

  logic accept;

  assign accept = valid && busy_n;
  assign drop   = valid && !busy_n;

  always_comb begin
    act = '0;
    if (accept) begin
      if (sel == BANK_SFR) begin
        case (addr)
          SF_CODEWR:  act.code_wr  = !pd;
          SF_SOFTCLR: act.soft_clr = !pd;
          SF_PDOWN:   act.pdown    = 1'b1;
          SF_PUP:     act.pup      = 1'b1;
          SF_SRESET:  act.sreset   = 1'b1;
          default:    act          = '0;
        endcase
      end else begin
        act.chan_wr = !pd;
        act.bank    = bank_e'(sel);
      end
    end
  end

endmodule

// File: rtl/dac_busy_timer.sv
module dac_busy_timer #(
  parameter int CW    = 8,
  parameter int N_CLR = 10,
  parameter int N_PUP = 4,
  parameter int N_RST = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_clr,
  input  logic start_pup,
  input  logic start_rst,
  output logic busy_n
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (start_rst)
      cnt_d = CW'(N_RST);
    else if (start_pup)
      cnt_d = CW'(N_PUP);
    else if (start_clr)
      cnt_d = CW'(N_CLR);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  assign cnt_en = start_rst || start_pup || start_clr || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign busy_n = (cnt_q == '0);

endmodule

// File: rtl/dac_chan_slot.sv
module dac_chan_slot
  import dac_cmd_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          zero_all,
  input  logic          load_clr,
  input  logic [DW-1:0] clr_code,
  input  logic          wr_en,
  input  bank_e         wr_bank,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] gain_o,
  output logic [DW-1:0] offs_o
);

  logic [DW-1:0] data_q, gain_q, offs_q;
  logic [DW-1:0] data_d, gain_d, offs_d;
  logic          slot_en;

  always_comb begin
    data_d = data_q;
    gain_d = gain_q;
    offs_d = offs_q;
    if (zero_all) begin
      data_d = '0;
      gain_d = '1;
      offs_d = '0;
    end else begin
      if (load_clr)
        data_d = clr_code;
      if (wr_en) begin
        case (wr_bank)
          BANK_GAIN: gain_d = wr_data;
          BANK_OFFS: offs_d = wr_data;
          BANK_DATA: if (!load_clr) data_d = wr_data;
          default:   data_d = data_d;
        endcase
      end
    end
  end

  assign slot_en = zero_all || load_clr || wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      gain_q <= '1;
      offs_q <= '0;
    end else if (slot_en) begin
      data_q <= data_d;
      gain_q <= gain_d;
      offs_q <= offs_d;
    end
  end

  assign data_o = data_q;
  assign gain_o = gain_q;
  assign offs_o = offs_q;

endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
  import dac_cmd_pkg::*;
#(
  parameter int NCH     = 32,
  parameter int DW      = 12,
  parameter int CLK_MHZ = 50,
  parameter int CLR_US  = 35,
  parameter int PUP_US  = 8,
  parameter int RST_US  = 135
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_sel_i,
  input  logic [4:0]          cmd_addr_i,
  input  logic [DW-1:0]       cmd_data_i,
  input  logic                hw_clr_n_i,
  input  logic                hw_pd_i,
  output logic                busy_n_o,
  output logic                pd_o,
  output logic                cmd_drop_o,
  output logic [DW-1:0]       clr_code_o,
  output logic [NCH*DW-1:0]   dac_data_o,
  output logic [NCH*DW-1:0]   gain_o,
  output logic [NCH*DW-1:0]   offset_o
);

  localparam int N_CLR  = CLK_MHZ * CLR_US;
  localparam int N_PUP  = CLK_MHZ * PUP_US;
  localparam int N_RST  = CLK_MHZ * RST_US;
  localparam int N_MAX  = (N_RST > N_CLR) ? ((N_RST > N_PUP) ? N_RST : N_PUP)
                                          : ((N_CLR > N_PUP) ? N_CLR : N_PUP);
  localparam int CNT_W  = $clog2(N_MAX + 1);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe_q <= 2'b00;
    else
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_sync_n = rst_pipe_q[1];

  logic       pd;
  logic       busy_n;
  logic       drop_evt;
  logic       load_clr;
  act_t       act;

  logic [DW-1:0] clr_code_q, clr_code_d;
  logic          sw_pd_q, sw_pd_d;
  logic          drop_q, drop_d;
  logic          ctl_en;

  assign pd = sw_pd_q || hw_pd_i;

  dac_cmd_decode i_decode (
    .valid  (cmd_valid_i),
    .sel    (cmd_sel_i),
    .addr   (cmd_addr_i),
    .busy_n (busy_n),
    .pd     (pd),
    .act    (act),
    .drop   (drop_evt)
  );

  dac_busy_timer #(
    .CW    (CNT_W),
    .N_CLR (N_CLR),
    .N_PUP (N_PUP),
    .N_RST (N_RST)
  ) i_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_clr (act.soft_clr),
    .start_pup (act.pup),
    .start_rst (act.sreset),
    .busy_n    (busy_n)
  );

  // clear request from either the command or the hardware pin
  assign load_clr = act.soft_clr || (!hw_clr_n_i && !pd);

  always_comb begin
    clr_code_d = clr_code_q;
    sw_pd_d    = sw_pd_q;
    drop_d     = drop_q;
    if (act.sreset) begin
      clr_code_d = '0;
      sw_pd_d    = 1'b0;
      drop_d     = 1'b0;
    end else begin
      if (act.code_wr) clr_code_d = cmd_data_i;
      if (act.pdown)   sw_pd_d    = 1'b1;
      if (act.pup)     sw_pd_d    = 1'b0;
      if (drop_evt)    drop_d     = 1'b1;
    end
  end

  assign ctl_en = act.sreset || act.code_wr || act.pdown || act.pup || drop_evt;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      clr_code_q <= '0;
      sw_pd_q    <= 1'b0;
      drop_q     <= 1'b0;
    end else if (ctl_en) begin
      clr_code_q <= clr_code_d;
      sw_pd_q    <= sw_pd_d;
      drop_q     <= drop_d;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic hit;
    assign hit = act.chan_wr && (cmd_addr_i == ADDR_W'(ch));

    dac_chan_slot #(
      .DW (DW)
    ) i_slot (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .zero_all (act.sreset),
      .load_clr (load_clr),
      .clr_code (clr_code_q),
      .wr_en    (hit),
      .wr_bank  (act.bank),
      .wr_data  (cmd_data_i),
      .data_o   (dac_data_o[ch*DW +: DW]),
      .gain_o   (gain_o[ch*DW +: DW]),
      .offs_o   (offset_o[ch*DW +: DW])
    );
  end

  assign busy_n_o   = busy_n;
  assign pd_o       = pd;
  assign cmd_drop_o = drop_q;
  assign clr_code_o = clr_code_q;

endmodule

// File: rtl/dac_cmd_ctrl_chk.sv
module dac_cmd_ctrl_chk #(
  parameter int NCH = 32,
  parameter int DW  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_sel_i,
  input logic [4:0]        cmd_addr_i,
  input logic [DW-1:0]     cmd_data_i,
  input logic              hw_pd_i,
  input logic              busy_n_o,
  input logic              pd_o,
  input logic              cmd_drop_o,
  input logic [DW-1:0]     clr_code_o,
  input logic [NCH*DW-1:0] dac_data_o,
  input logic [NCH*DW-1:0] gain_o,
  input logic [NCH*DW-1:0] offset_o
);

  localparam logic [DW-1:0] FULL = '1;

  logic sf_acc;
  assign sf_acc = cmd_valid_i && busy_n_o && (cmd_sel_i == 2'b00);

  assert_codewr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_acc && cmd_addr_i == 5'h01 && !pd_o) |=> (clr_code_o == $past(cmd_data_i)));

  assert_softclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_acc && cmd_addr_i == 5'h02 && !pd_o) |=>
      (!busy_n_o && dac_data_o == {NCH{$past(clr_code_o)}}));

  assert_pd_or_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_pd_i |-> pd_o);

  assert_pd_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_o && !(sf_acc && cmd_addr_i == 5'h0F)) |=>
      ($stable(dac_data_o) && $stable(gain_o) && $stable(offset_o) && $stable(clr_code_o)));

  assert_pup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_acc && cmd_addr_i == 5'h09) |=> (!busy_n_o && pd_o == hw_pd_i));

  assert_sreset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_acc && cmd_addr_i == 5'h0F) |=>
      (!busy_n_o && dac_data_o == '0 && offset_o == '0 && gain_o == {NCH{FULL}}
       && clr_code_o == '0 && !cmd_drop_o));

  assert_drop_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && !busy_n_o) |=> cmd_drop_o);

  assert_drop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_drop_o && !(sf_acc && cmd_addr_i == 5'h0F)) |=> cmd_drop_o);

endmodule

bind dac_cmd_ctrl dac_cmd_ctrl_chk #(
  .NCH (NCH),
  .DW  (DW)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cmd_valid_i (cmd_valid_i),
  .cmd_sel_i   (cmd_sel_i),
  .cmd_addr_i  (cmd_addr_i),
  .cmd_data_i  (cmd_data_i),
  .hw_pd_i     (hw_pd_i),
  .busy_n_o    (busy_n_o),
  .pd_o        (pd_o),
  .cmd_drop_o  (cmd_drop_o),
  .clr_code_o  (clr_code_o),
  .dac_data_o  (dac_data_o),
  .gain_o      (gain_o),
  .offset_o    (offset_o)
);

// File: tb/test_dac_cmd_ctrl.sv
module test_dac_cmd_ctrl;

  localparam int NCH     = 8;
  localparam int DW      = 12;
  localparam int CLK_MHZ = 2;
  localparam int N_CLR   = CLK_MHZ * 35;
  localparam int N_PUP   = CLK_MHZ * 8;
  localparam int N_RST   = CLK_MHZ * 135;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid_i = 1'b0;
  logic [1:0]        cmd_sel_i = '0;
  logic [4:0]        cmd_addr_i = '0;
  logic [DW-1:0]     cmd_data_i = '0;
  logic              hw_clr_n_i = 1'b1;
  logic              hw_pd_i = 1'b0;
  logic              busy_n_o;
  logic              pd_o;
  logic              cmd_drop_o;
  logic [DW-1:0]     clr_code_o;
  logic [NCH*DW-1:0] dac_data_o;
  logic [NCH*DW-1:0] gain_o;
  logic [NCH*DW-1:0] offset_o;

  always #10 clk = ~clk;

  dac_cmd_ctrl #(
    .NCH(NCH), .DW(DW), .CLK_MHZ(CLK_MHZ), .CLR_US(35), .PUP_US(8), .RST_US(135)
  ) i_dac_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_sel_i(cmd_sel_i),
    .cmd_addr_i(cmd_addr_i), .cmd_data_i(cmd_data_i), .hw_clr_n_i(hw_clr_n_i),
    .hw_pd_i(hw_pd_i), .busy_n_o(busy_n_o), .pd_o(pd_o), .cmd_drop_o(cmd_drop_o),
    .clr_code_o(clr_code_o), .dac_data_o(dac_data_o), .gain_o(gain_o), .offset_o(offset_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    due;
    int    kind;
    int    idx;
    int    exp;
    string req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model
  int m_data[NCH];
  int m_gain[NCH];
  int m_offs[NCH];
  int m_clr, m_swpd, m_hwpd, m_drop;
  int busy_last = -1;

  function automatic int observe(int kind, int idx);
    case (kind)
      0: return int'(dac_data_o[idx*DW +: DW]);
      1: return int'(gain_o[idx*DW +: DW]);
      2: return int'(offset_o[idx*DW +: DW]);
      3: return int'(clr_code_o);
      4: return int'(pd_o);
      5: return int'(cmd_drop_o);
      default: return int'(busy_n_o);
    endcase
  endfunction

  function automatic void expect_val(int due, int kind, int idx, int exp, string r);
    item_t it;
    it.due = due; it.kind = kind; it.idx = idx; it.exp = exp; it.req = r;
    q.push_back(it);
  endfunction

  function automatic void push_all(int due, string r);
    for (int c = 0; c < NCH; c++) begin
      expect_val(due, 0, c, m_data[c], r);
      expect_val(due, 1, c, m_gain[c], r);
      expect_val(due, 2, c, m_offs[c], r);
    end
    expect_val(due, 3, 0, m_clr, r);
    expect_val(due, 4, 0, (m_swpd | m_hwpd), r);
    expect_val(due, 5, 0, m_drop, r);
    expect_val(due, 6, 0, (due <= busy_last) ? 0 : 1, r);
  endfunction

  function automatic void model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_data[c] = 0; m_gain[c] = (1 << DW) - 1; m_offs[c] = 0;
    end
    m_clr = 0; m_swpd = 0; m_drop = 0;
  endfunction

  function automatic void start_busy(int k, int n, string r);
    busy_last = k + n;
    expect_val(k + 1, 6, 0, 0, r);
    expect_val(k + n, 6, 0, 0, r);
    expect_val(k + n + 1, 6, 0, 1, r);
  endfunction

  function automatic void model_step(int k, bit v, int s, int a, int d, bit hc, string r);
    bit pd = (m_swpd | m_hwpd) != 0;
    int old_clr = m_clr;
    bit acc = v && (k > busy_last);
    bit did_rst = 1'b0;
    if (v && !acc) m_drop = 1;
    if (acc) begin
      if (s == 0) begin
        case (a)
          1: if (!pd) m_clr = d;
          2: if (!pd) begin
               for (int c = 0; c < NCH; c++) m_data[c] = old_clr;
               start_busy(k, N_CLR, r);
             end
          8: m_swpd = 1;
          9: begin m_swpd = 0; start_busy(k, N_PUP, r); end
          15: begin model_reset(); did_rst = 1'b1; start_busy(k, N_RST, r); end
          default: ;
        endcase
      end else if (!pd && a < NCH) begin
        case (s)
          1: m_gain[a] = d;
          2: m_offs[a] = d;
          default: m_data[a] = d;
        endcase
      end
    end
    if (hc && !pd && !did_rst)
      for (int c = 0; c < NCH; c++) m_data[c] = old_clr;
  endfunction

  task automatic cmd(int s, int a, int d, bit hc, string r);
    int k;
    @(negedge clk);
    k = cyc;
    cmd_valid_i = 1'b1; cmd_sel_i = 2'(s); cmd_addr_i = 5'(a); cmd_data_i = DW'(d);
    hw_clr_n_i = !hc;
    model_step(k, 1'b1, s, a, d, hc, r);
    push_all(k + 1, r);
    @(negedge clk);
    cmd_valid_i = 1'b0; hw_clr_n_i = 1'b1;
  endtask

  task automatic hwclr(string r);
    int k;
    @(negedge clk);
    k = cyc;
    hw_clr_n_i = 1'b0;
    model_step(k, 1'b0, 0, 0, 0, 1'b1, r);
    push_all(k + 1, r);
    @(negedge clk);
    hw_clr_n_i = 1'b1;
  endtask

  task automatic set_hwpd(bit v, string r);
    @(negedge clk);
    hw_pd_i = v;
    m_hwpd = v;
    push_all(cyc + 1, r);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (cyc <= busy_last + 1) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      foreach (q[i]) begin
        checks++; errors++;
        $display("FAIL %s stale expectation kind %0d idx %0d exp %0h due %0d",
                 q[i].req, q[i].kind, q[i].idx, q[i].exp, q[i].due);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: compare every item due in the current cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        int got;
        got = observe(q[i].kind, q[i].idx);
        checks++;
        if (got != q[i].exp) begin
          errors++;
          $display("FAIL %s kind %0d idx %0d actual %0h expected %0h cycle %0d",
                   q[i].req, q[i].kind, q[i].idx, got, q[i].exp, cyc);
        end
        q.delete(i);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    model_reset();
    m_hwpd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    push_all(cyc + 1, "R1");
    @(negedge clk);

    // R2 channel writes in each bank, plus an out-of-range channel
    cmd(3, 3, 'hABC, 0, "R2");
    cmd(1, 5, 'h123, 0, "R2");
    cmd(2, 0, 'h456, 0, "R2");
    cmd(3, 7, 'h7FF, 0, "R2");
    cmd(3, 8, 'h999, 0, "R2");
    cmd(1, 31, 'h321, 0, "R2");

    // R3 clear code load
    cmd(0, 1, 'h5A5, 0, "R3");

    // R11 no-op and unassigned function codes
    cmd(0, 0, 'hFFF, 0, "R11");
    cmd(0, 5, 'h0F0, 0, "R11");
    cmd(0, 31, 'h00F, 0, "R11");

    // R4 soft clear with junk data, then R10 command during busy
    cmd(0, 2, 'h3C3, 0, "R4");
    cmd(3, 1, 'h0EE, 0, "R10");
    wait_idle();
    cmd(2, 6, 'h0AA, 0, "R10");

    // R5 hardware clear, alone and against a data write
    cmd(0, 1, 'h111, 0, "R5");
    cmd(3, 2, 'h222, 1, "R5");
    cmd(0, 1, 'h0F0, 0, "R5");
    hwclr("R5");

    // R6 software power-down; R7 writes blocked
    cmd(0, 8, 'h000, 0, "R6");
    cmd(3, 4, 'h444, 0, "R7");
    cmd(1, 4, 'h555, 0, "R7");
    cmd(0, 1, 'h777, 0, "R7");
    cmd(0, 2, 'h000, 0, "R7");
    hwclr("R7");

    // R8 power-up accepted while powered down
    cmd(0, 9, 'h000, 0, "R8");
    wait_idle();

    // R6 hardware power-down; R7 blocked write; R8 power-up cannot lift it
    set_hwpd(1'b1, "R6");
    cmd(3, 4, 'h444, 0, "R7");
    cmd(0, 9, 'h000, 0, "R8");
    wait_idle();
    set_hwpd(1'b0, "R6");
    cmd(3, 4, 'h444, 0, "R2");

    // R9 soft reset while powered down restores defaults
    cmd(1, 2, 'h0C0, 0, "R9");
    cmd(2, 3, 'h0D0, 0, "R9");
    cmd(0, 8, 'h000, 0, "R9");
    cmd(0, 15, 'hFFF, 0, "R9");
    wait_idle();
    cmd(3, 0, 'h00A, 0, "R9");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule